// File: doc/BRIEF.md
# Word-Wide GPIO Port with Atomic Bit Set and Clear

This block is a general-purpose I/O port that sits on a simple synchronous register bus. One data register holds the value driven onto the output pins. Writing that register replaces every output bit at once. Two optional write-only registers change selected bits without disturbing the rest. In the first, each 1 in the written word forces the matching data bit high. In the second, each 1 forces the matching bit low. Software can therefore flip a single line without reading the register first, so two agents sharing the port cannot lose each other's updates.

The port is one register wide. The width is a parameter limited to 8, 16, 32 or 64, and there is one pin per register bit. There is no direction register. Every line is always driven from the data register, and a parameter mask marks which lines are read back from the pins instead. Pin inputs pass through a two-stage synchroniser before they reach the read path. A second parameter reverses the numbering between pin index and register bit, for software that counts bits from the most significant end.

Reads are registered: the value appears on the read data port one clock after the read enable and stays there until the next read. Reset is asynchronous and active-low, and its release is expected to be synchronous to the clock.

Top module: `gpio_word_port`

## Requirements
- R1: While reset is asserted and right after its release, `pin_out` and `bus_rdata` are all zeros.
- R2: A write at word offset 0 loads `bus_wdata` into the whole data register at that clock edge. The data register holds its value in any cycle with no write to offsets 0, 1 or 2.
- R3: With set/clear present, a write at offset 1 sets to 1 every data bit where the written word is 1 and leaves all other bits unchanged.
- R4: With set/clear present, a write at offset 2 clears to 0 every data bit where the written word is 1 and leaves all other bits unchanged.
- R5: With set/clear absent (`HAS_SETCLR`=0), writes at offsets 1 and 2 leave the data register and the pins unchanged.
- R6: A read at any offset other than 0 returns all zeros. A write at offset 3 is ignored.
- R7: With `BIG_ENDIAN`=0, `pin_out[n]` is data register bit n. With `BIG_ENDIAN`=1, `pin_out[n]` is data register bit WIDTH-1-n, so in an 8-bit port writing 0x01 drives pin 7.
- R8: On a read at offset 0, register bit b returns the value of the pin mapped to it. If that pin's bit is set in `IN_MASK` (indexed by pin number), the value is the synchronised `pin_in`. Otherwise it is the driven `pin_out`.
- R9: Read data is valid on the clock edge after the one that samples `bus_rd`. It holds while `bus_rd` is low, including across writes.
- R10: When a read and a write at offset 0 fall in the same cycle, the read returns the value from before the write.
- R11: A change on `pin_in` reaches the read path only after two clock edges. With `bus_rd` held high at offset 0, reads captured on the first and second edges after the change return the old value, and the read captured on the third edge returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word offset: 0 data, 1 set, 2 clear |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | WIDTH | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Asynchronous pin inputs, indexed by pin |
| pin_out | output | WIDTH | Driven pin values, indexed by pin |

## Verification
A read of the data register can share a cycle with a write to it, and a pin change can arrive while reads are streaming. The bench drives a read and a data write on the same edge and expects the pre-write readback on the bus together with the new value on the pins. It then holds the read enable high while one pin nibble changes, and expects the old value for two captures and the new value on the third. Two instances, one with normal numbering and set/clear and one with reversed numbering and no set/clear, share the bus so that each write is judged against both mappings at once.

// File: rtl/gpio_word_pkg.sv
package gpio_word_pkg;

  typedef enum logic [1:0] {
    OFS_DATA = 2'd0,
    OFS_SET  = 2'd1,
    OFS_CLR  = 2'd2,
    OFS_NONE = 2'd3
  } gw_ofs_e;

  typedef struct packed {
    logic wr_data;
    logic wr_set;
    logic wr_clr;
    logic rd_data;
    logic rd_zero;
  } gw_dec_t;

  function automatic bit gw_width_ok(input int w);
    return (w == 8) || (w == 16) || (w == 32) || (w == 64);
  endfunction

endpackage

// File: rtl/gpio_word_decode.sv
module gpio_word_decode
  import gpio_word_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter bit HAS_SETCLR = 1'b1
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output gw_dec_t           dec
);

  logic    hit;
  gw_ofs_e ofs;

  // Only the lowest word offsets exist; any higher address misses.
  assign hit = ((bus_addr >> 2) == '0);
  assign ofs = gw_ofs_e'(bus_addr[1:0]);

  always_comb begin
    dec = '0;
    if (hit) begin
      unique case (ofs)
        OFS_DATA: begin
          dec.wr_data = bus_wr;
          dec.rd_data = bus_rd;
        end
        OFS_SET:  dec.wr_set = bus_wr & HAS_SETCLR;
        OFS_CLR:  dec.wr_clr = bus_wr & HAS_SETCLR;
        default:  ;
      endcase
    end
    dec.rd_zero = bus_rd & ~dec.rd_data;
  end

endmodule

// File: rtl/gpio_word_store.sv
module gpio_word_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data_q
);

  logic [W-1:0] data_nxt;
  logic         data_en;

  // Clear is applied before set, so set wins if both ever fire together.
  always_comb begin
    data_nxt = data_q;
    if (wr_data) data_nxt = wdata;
    if (wr_clr)  data_nxt = data_nxt & ~wdata;
    if (wr_set)  data_nxt = data_nxt | wdata;
  end

  assign data_en = wr_data | wr_set | wr_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_nxt;
  end

  a_r2_full_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !wr_set && !wr_clr) |=> (data_q == $past(wdata)));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_data && !wr_set && !wr_clr) |=> $stable(data_q));

  a_r3_set_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && !wr_data) |=>
      (((data_q & $past(wdata)) == $past(wdata)) &&
       ((data_q & ~$past(wdata)) == ($past(data_q) & ~$past(wdata)))));

  a_r4_clear_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wr_set && !wr_data) |=>
      (((data_q & $past(wdata)) == '0) &&
       ((data_q & ~$past(wdata)) == ($past(data_q) & ~$past(wdata)))));

endmodule

// File: rtl/gpio_word_sync.sv
module gpio_word_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign sync_out = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_word_remap.sv
module gpio_word_remap #(
  parameter int W       = 8,
  parameter bit REVERSE = 1'b0
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] dst
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (REVERSE) begin : g_rev
      assign dst[i] = src[W-1-i];
    end else begin : g_str
      assign dst[i] = src[i];
    end
  end

endmodule

// File: rtl/gpio_word_port.sv
module gpio_word_port
  import gpio_word_pkg::*;
#(
  parameter int             WIDTH      = 8,
  parameter int             ADDR_W     = 2,
  parameter bit             HAS_SETCLR = 1'b1,
  parameter bit             BIG_ENDIAN = 1'b0,
  parameter logic [WIDTH-1:0] IN_MASK  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out
);

  localparam bit WIDTH_OK    = gw_width_ok(WIDTH);
  localparam int SYNC_STAGES = 2;

  if (!WIDTH_OK) begin : g_bad_width
    $error("gpio_word_port: WIDTH must be 8, 16, 32 or 64");
  end

  gw_dec_t          dec;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] pins_sync;
  logic [WIDTH-1:0] rb_pin;
  logic [WIDTH-1:0] rb_reg;
  logic [WIDTH-1:0] rdata_nxt;
  logic             rdata_en;

  gpio_word_decode #(
    .ADDR_W     (ADDR_W),
    .HAS_SETCLR (HAS_SETCLR)
  ) u_decode (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .dec      (dec)
  );

  gpio_word_store #(
    .W (WIDTH)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_data (dec.wr_data),
    .wr_set  (dec.wr_set),
    .wr_clr  (dec.wr_clr),
    .wdata   (bus_wdata),
    .data_q  (data_q)
  );

  // Register bits to pins.
  gpio_word_remap #(
    .W       (WIDTH),
    .REVERSE (BIG_ENDIAN)
  ) u_map_out (
    .src (data_q),
    .dst (pin_out)
  );

  gpio_word_sync #(
    .W      (WIDTH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pins_sync)
  );

  // Readback is chosen per pin, then mapped back into register bit order.
  assign rb_pin = (IN_MASK & pins_sync) | (~IN_MASK & pin_out);

  gpio_word_remap #(
    .W       (WIDTH),
    .REVERSE (BIG_ENDIAN)
  ) u_map_in (
    .src (rb_pin),
    .dst (rb_reg)
  );

  always_comb begin
    rdata_nxt = '0;
    if (dec.rd_data) rdata_nxt = rb_reg;
  end

  assign rdata_en = dec.rd_data | dec.rd_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_rdata <= '0;
    else if (rdata_en) bus_rdata <= rdata_nxt;
  end

  a_r6_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr != '0)) |=> (bus_rdata == '0));

  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  a_r7_pin_order: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out[0] == (BIG_ENDIAN ? data_q[WIDTH-1] : data_q[0]));

  a_r5_no_setclr: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_SETCLR && bus_wr && (bus_addr != '0)) |=> $stable(pin_out));

endmodule

// File: tb/gpio_word_port_bench.sv
module gpio_word_port_bench;

  logic       clk;
  logic       rst_n;
  logic [1:0] addr;
  logic       wr;
  logic [7:0] wdata;
  logic       rd;
  logic [7:0] rdata_a, rdata_b;
  logic [7:0] pin_in_a, pin_in_b;
  logic [7:0] pin_out_a, pin_out_b;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] ma, mb;   // bench models of the two data registers

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Normal numbering, set/clear present, pins 7..4 read from inputs.
  gpio_word_port #(
    .WIDTH (8), .ADDR_W (2), .HAS_SETCLR (1'b1), .BIG_ENDIAN (1'b0), .IN_MASK (8'hF0)
  ) u_gpio_word_port (
    .clk (clk), .rst_n (rst_n), .bus_addr (addr), .bus_wr (wr), .bus_wdata (wdata),
    .bus_rd (rd), .bus_rdata (rdata_a), .pin_in (pin_in_a), .pin_out (pin_out_a)
  );

  // Reversed numbering, no set/clear, pins 3..0 read from inputs.
  gpio_word_port #(
    .WIDTH (8), .ADDR_W (2), .HAS_SETCLR (1'b0), .BIG_ENDIAN (1'b1), .IN_MASK (8'h0F)
  ) u_gpio_word_port_be (
    .clk (clk), .rst_n (rst_n), .bus_addr (addr), .bus_wr (wr), .bus_wdata (wdata),
    .bus_rd (rd), .bus_rdata (rdata_b), .pin_in (pin_in_b), .pin_out (pin_out_b)
  );

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [7:0] exp_rb_a();
    return (8'hF0 & pin_in_a) | (8'h0F & ma);
  endfunction

  function automatic logic [7:0] exp_rb_b();
    return rev8((8'h0F & pin_in_b) | (8'hF0 & rev8(mb)));
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    case (a)
      2'd0: begin ma = d; mb = d; end
      2'd1: ma = ma | d;
      2'd2: ma = ma & ~d;
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] ra, output logic [7:0] rb);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    ra = rdata_a; rb = rdata_b;
  endtask

  task automatic t_reset();
    chk("R1 pin_out_a at reset", pin_out_a, 8'h00);
    chk("R1 pin_out_b at reset", pin_out_b, 8'h00);
    chk("R1 rdata_a at reset", rdata_a, 8'h00);
    chk("R1 rdata_b at reset", rdata_b, 8'h00);
  endtask

  task automatic t_data_write();
    bus_write(2'd0, 8'h1E);
    chk("R2 data load a", pin_out_a, ma);
    chk("R7 reversed pins b", pin_out_b, rev8(mb));
    bus_write(2'd0, 8'h01);
    chk("R7 normal bit0 a", pin_out_a, 8'h01);
    chk("R7 reversed bit0 drives pin7 b", pin_out_b, 8'h80);
    bus_write(2'd0, 8'h1E);
  endtask

  task automatic t_set();
    bus_write(2'd1, 8'h81);
    chk("R3 set a", pin_out_a, 8'h9F);
    chk("R5 set ignored b", pin_out_b, rev8(8'h1E));
  endtask

  task automatic t_clear();
    bus_write(2'd2, 8'h0C);
    chk("R4 clear a", pin_out_a, 8'h93);
    chk("R5 clear ignored b", pin_out_b, rev8(8'h1E));
  endtask

  task automatic t_unused();
    logic [7:0] ra, rb;
    bus_write(2'd3, 8'hFF);
    chk("R6 offset3 write a", pin_out_a, 8'h93);
    chk("R6 offset3 write b", pin_out_b, rev8(8'h1E));
    for (int o = 1; o < 4; o++) begin
      bus_read(o[1:0], ra, rb);
      chk("R6 other read a", ra, 8'h00);
      chk("R6 other read b", rb, 8'h00);
    end
  endtask

  task automatic t_readback();
    logic [7:0] ra, rb;
    pin_in_a = 8'hA5; pin_in_b = 8'h3C;
    repeat (3) @(negedge clk);
    bus_read(2'd0, ra, rb);
    chk("R8 readback a", ra, exp_rb_a());
    chk("R8 readback b", rb, exp_rb_b());
  endtask

  task automatic t_rd_hold();
    logic [7:0] ra, rb;
    bus_read(2'd0, ra, rb);
    bus_write(2'd0, 8'h44);
    repeat (2) @(negedge clk);
    chk("R9 hold a", rdata_a, ra);
    chk("R9 hold b", rdata_b, rb);
  endtask

  task automatic t_rw_same();
    logic [7:0] old_a, old_b;
    old_a = exp_rb_a(); old_b = exp_rb_b();
    @(negedge clk);
    addr = 2'd0; wr = 1'b1; rd = 1'b1; wdata = 8'h0B;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    ma = 8'h0B; mb = 8'h0B;
    chk("R10 read before write a", rdata_a, old_a);
    chk("R10 read before write b", rdata_b, old_b);
    chk("R10 write taken a", pin_out_a, 8'h0B);
  endtask

  task automatic t_sync_lag();
    logic [7:0] old_a;
    old_a = exp_rb_a();
    @(negedge clk);
    addr = 2'd0; rd = 1'b1; pin_in_a = 8'h5A;
    @(negedge clk);
    chk("R11 first capture old", rdata_a, old_a);
    @(negedge clk);
    chk("R11 second capture old", rdata_a, old_a);
    @(negedge clk);
    rd = 1'b0;
    chk("R11 third capture new", rdata_a, exp_rb_a());
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    pin_in_a = '0; pin_in_b = '0; ma = '0; mb = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_write();
    t_set();
    t_clear();
    t_unused();
    t_readback();
    t_rd_hold();
    t_rw_same();
    t_sync_lag();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule